// File: doc/BRIEF.md
# Banked Register File Operand Collector

This block sits between instruction issue and a SIMD execution unit. It collects the source operands for each issued instruction. The operands come from a register file of four single-ported banks. Each accepted instruction takes one of four collector units. A unit has three operand rows, and each row holds a valid bit, a register number, a ready bit and a 32-bit value. Rows that still need data ask for their bank. A rotating-priority arbiter in each bank picks one row per cycle, so several units can fill at once from different banks. A writeback to a bank blocks that bank's reads for the cycle.

The bank of a register turns with the warp number, so warps at the same point in their code touch different banks for the same register name. A unit whose valid rows are all filled goes to the execution unit and is freed in the same cycle. Instructions may leave in an order other than the one they arrived in. Issue logic watches the free flag and holds an instruction until the flag is high. An instruction offered while no unit is idle is dropped and must be offered again.

Top module: `oc_collector`

## Requirements
- R1: Register r of warp w lives in bank (r + w) mod 4 (8 warps, 16 registers). Sources in different banks are read in the same cycle. Sources sharing a bank are read one per cycle.
- R2: Each bank serves one access per cycle. A writeback goes ahead of any read of its bank in that cycle. A delayed read then returns the written value. A writeback to another bank does not delay the read.
- R3: If an instruction is accepted in cycle a, each granted read fills its row one cycle after the grant. With all sources in distinct banks and no writebacks, dispatch happens in cycle a+2. An instruction with no valid source dispatches in cycle a+1.
- R4: Dispatch presents warp, opcode and the three source-valid bits. Operand k sits at disp_operands[32k+31:32k], and source k at alloc_src_reg[4k+3:4k]. Slots of rows that are not valid read zero.
- R5: There are four collector units, and cu_free is high exactly when one is idle. An allocation offered while cu_free is low is dropped and never dispatched. A unit is free again after it dispatches, so a retry is accepted.
- R6: At most one unit dispatches per cycle. When several units are fully ready, the lowest-indexed one goes first. A later instruction may dispatch before an earlier one.
- R7: Each bank grants in rotating priority over row index unit*3+row. After a grant, the search starts just past the granted index. The pointer resets to index 0.
- R8: After reset every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Instruction offered for collection |
| alloc_warp | input | 3 | Warp of the offered instruction |
| alloc_op | input | 6 | Opcode, carried through to dispatch |
| alloc_src_vld | input | 3 | Valid bit per source row |
| alloc_src_reg | input | 12 | Source register numbers, 4 bits per row |
| cu_free | output | 1 | At least one collector unit is idle |
| wb_valid | input | 1 | Writeback this cycle |
| wb_warp | input | 3 | Writeback warp |
| wb_reg | input | 4 | Writeback register number |
| wb_data | input | 32 | Writeback value |
| disp_valid | output | 1 | A unit dispatches this cycle |
| disp_warp | output | 3 | Warp of the dispatching instruction |
| disp_op | output | 6 | Opcode of the dispatching instruction |
| disp_src_vld | output | 3 | Source-valid bits of the dispatching instruction |
| disp_operands | output | 96 | Operand values, 32 bits per row |

## Verification
A bad bank mapping or a broken arbiter shows up at the ports as a dispatch one or more cycles early or late. Dispatch times for known source patterns are therefore compared cycle for cycle. A row that latches from the wrong bank or before a writeback lands shows wrong operand data in the dispatch cycle itself. A wrong rotation pointer or wrong unit selection reverses the order of two dispatches that are only one cycle apart. The tests build these situations with writebacks that hold a bank blocked. A lost free flag shows as a dropped instruction that comes out anyway, or as a retry that is never accepted.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int NUM_CU     = 4;
  localparam int NUM_ROWS   = 3;
  localparam int DATA_W     = 32;
  localparam int NUM_WARPS  = 8;
  localparam int NUM_REGS   = 16;
  localparam int OP_W       = 6;

  localparam int WARP_W     = $clog2(NUM_WARPS);
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int CU_W       = $clog2(NUM_CU);
  localparam int NUM_REQ    = NUM_CU * NUM_ROWS;
  localparam int BADDR_W    = WARP_W + REG_W - BANK_W;
  localparam int BANK_DEPTH = 1 << BADDR_W;

  typedef struct packed {
    logic              vld;
    logic              rdy;
    logic [REG_W-1:0]  rnum;
    logic [DATA_W-1:0] val;
  } row_t;

  // warp-rotated bank choice: (reg + warp) mod banks
  function automatic logic [BANK_W-1:0] bank_of(input logic [WARP_W-1:0] w,
                                                input logic [REG_W-1:0] r);
    return r[BANK_W-1:0] + w[BANK_W-1:0];
  endfunction

  // row within a bank: warp number above the register's upper bits
  function automatic logic [BADDR_W-1:0] bank_addr(input logic [WARP_W-1:0] w,
                                                   input logic [REG_W-1:0] r);
    return {w, r[REG_W-1:BANK_W]};
  endfunction
endpackage

// File: rtl/oc_regbank.sv
module oc_regbank #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/oc_rr_arb.sv
module oc_rr_arb #(
  parameter int N  = 12,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] ptr, gidx;
  logic          found;

  always_comb begin
    logic [IW:0] idx;
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = {1'b0, ptr} + (IW+1)'(i);
      if (idx >= (IW+1)'(N)) idx = idx - (IW+1)'(N);
      if (!found && req[idx[IW-1:0]]) begin
        gnt[idx[IW-1:0]] = 1'b1;
        gidx  = idx[IW-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (found) ptr <= (gidx == IW'(N-1)) ? '0 : gidx + 1'b1;
  end
endmodule

// File: rtl/oc_collector.sv
module oc_collector
  import oc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic [WARP_W-1:0]          alloc_warp,
  input  logic [OP_W-1:0]            alloc_op,
  input  logic [NUM_ROWS-1:0]        alloc_src_vld,
  input  logic [NUM_ROWS*REG_W-1:0]  alloc_src_reg,
  output logic                       cu_free,
  input  logic                       wb_valid,
  input  logic [WARP_W-1:0]          wb_warp,
  input  logic [REG_W-1:0]           wb_reg,
  input  logic [DATA_W-1:0]          wb_data,
  output logic                       disp_valid,
  output logic [WARP_W-1:0]          disp_warp,
  output logic [OP_W-1:0]            disp_op,
  output logic [NUM_ROWS-1:0]        disp_src_vld,
  output logic [NUM_ROWS*DATA_W-1:0] disp_operands
);
  logic [NUM_CU-1:0] cu_busy, cu_all_rdy, disp_oh;
  logic [WARP_W-1:0] cu_warp [NUM_CU];
  logic [OP_W-1:0]   cu_op   [NUM_CU];
  row_t              rows    [NUM_CU][NUM_ROWS];

  // lowest idle unit takes the next instruction
  logic [CU_W-1:0] alloc_sel;
  logic            alloc_fire;
  always_comb begin
    alloc_sel = '0;
    cu_free   = 1'b0;
    for (int c = NUM_CU - 1; c >= 0; c--) begin
      if (!cu_busy[c]) begin
        alloc_sel = CU_W'(c);
        cu_free   = 1'b1;
      end
    end
  end
  assign alloc_fire = alloc_valid && cu_free;

  // flattened row view, index = unit*rows + row
  logic [NUM_REQ-1:0] req_pend, row_gnt, row_rdy_flat;
  logic [BANK_W-1:0]  req_bank [NUM_REQ];
  logic [BADDR_W-1:0] req_addr [NUM_REQ];

  for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int IDX = c * NUM_ROWS + r;
      assign req_pend[IDX]     = cu_busy[c] && rows[c][r].vld && !rows[c][r].rdy;
      assign req_bank[IDX]     = bank_of(cu_warp[c], rows[c][r].rnum);
      assign req_addr[IDX]     = bank_addr(cu_warp[c], rows[c][r].rnum);
      assign row_rdy_flat[IDX] = rows[c][r].rdy;
    end
  end

  // writeback decode
  logic [BANK_W-1:0]  wb_bank;
  logic [BADDR_W-1:0] wb_addr;
  assign wb_bank = bank_of(wb_warp, wb_reg);
  assign wb_addr = bank_addr(wb_warp, wb_reg);

  logic [NUM_BANKS-1:0]              wb_we, bank_rd_en;
  logic [NUM_BANKS-1:0][NUM_REQ-1:0] bank_req, bank_gnt;
  logic [DATA_W-1:0]                 bank_rdata [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BADDR_W-1:0] raddr;
    assign wb_we[b] = wb_valid && (wb_bank == BANK_W'(b));

    // a writeback owns the bank: no row may ask for it this cycle
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
      assign bank_req[b][i] = req_pend[i] && (req_bank[i] == BANK_W'(b)) && !wb_we[b];
    end

    oc_rr_arb #(.N(NUM_REQ)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (bank_req[b]),
      .gnt   (bank_gnt[b])
    );

    assign bank_rd_en[b] = |bank_gnt[b];

    always_comb begin
      raddr = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (bank_gnt[b][i]) raddr = req_addr[i];
      end
    end

    oc_regbank #(.DEPTH(BANK_DEPTH), .AW(BADDR_W), .DW(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wb_we[b]),
      .addr  (wb_we[b] ? wb_addr : raddr),
      .wdata (wb_data),
      .rdata (bank_rdata[b])
    );
  end

  always_comb begin
    row_gnt = '0;
    for (int b = 0; b < NUM_BANKS; b++) row_gnt = row_gnt | bank_gnt[b];
  end

  // dispatch: lowest-index unit with every valid row filled
  always_comb begin
    logic found;
    found = 1'b0;
    disp_oh = '0;
    for (int c = 0; c < NUM_CU; c++) begin
      cu_all_rdy[c] = cu_busy[c];
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (rows[c][r].vld && !rows[c][r].rdy) cu_all_rdy[c] = 1'b0;
      end
      if (!found && cu_all_rdy[c]) begin
        disp_oh[c] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    disp_valid    = |disp_oh;
    disp_warp     = '0;
    disp_op       = '0;
    disp_src_vld  = '0;
    disp_operands = '0;
    for (int c = 0; c < NUM_CU; c++) begin
      if (disp_oh[c]) begin
        disp_warp = cu_warp[c];
        disp_op   = cu_op[c];
        for (int r = 0; r < NUM_ROWS; r++) begin
          disp_src_vld[r]                    = rows[c][r].vld;
          disp_operands[r*DATA_W +: DATA_W]  = rows[c][r].val;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cu_busy <= '0;
      for (int c = 0; c < NUM_CU; c++) begin
        cu_warp[c] <= '0;
        cu_op[c]   <= '0;
        for (int r = 0; r < NUM_ROWS; r++) rows[c][r] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CU; c++) begin
        if (disp_oh[c]) cu_busy[c] <= 1'b0;
        if (alloc_fire && alloc_sel == CU_W'(c)) begin
          cu_busy[c] <= 1'b1;
          cu_warp[c] <= alloc_warp;
          cu_op[c]   <= alloc_op;
          for (int r = 0; r < NUM_ROWS; r++) begin
            rows[c][r].vld  <= alloc_src_vld[r];
            rows[c][r].rnum <= alloc_src_reg[r*REG_W +: REG_W];
            rows[c][r].rdy  <= 1'b0;
            rows[c][r].val  <= '0;
          end
        end
        for (int r = 0; r < NUM_ROWS; r++) begin
          if (row_gnt[c*NUM_ROWS + r]) begin
            rows[c][r].rdy <= 1'b1;
            rows[c][r].val <= bank_rdata[req_bank[c*NUM_ROWS + r]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/oc_collector_chk.sv
module oc_collector_chk
  import oc_pkg::*;
(
  input logic                              clk,
  input logic                              rst_n,
  input logic                              alloc_valid,
  input logic                              cu_free,
  input logic                              disp_valid,
  input logic [NUM_CU-1:0]                 cu_busy,
  input logic [NUM_CU-1:0]                 disp_oh,
  input logic [NUM_BANKS-1:0]              wb_we,
  input logic [NUM_BANKS-1:0]              bank_rd_en,
  input logic [NUM_BANKS-1:0][NUM_REQ-1:0] bank_req,
  input logic [NUM_BANKS-1:0][NUM_REQ-1:0] bank_gnt,
  input logic [NUM_REQ-1:0]                row_gnt,
  input logic [NUM_REQ-1:0]                row_rdy_flat
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bchk
    p_single_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_we[b] && bank_rd_en[b]));
    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_gnt[b]));
    p_grant_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_gnt[b] & ~bank_req[b]) == '0);
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_rchk
    p_fill_next_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      row_gnt[i] |=> row_rdy_flat[i]);
  end

  p_single_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_oh));

  p_release_after_dispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> cu_free);

  p_alloc_takes_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && cu_free && !disp_valid) |=>
      ($countones(cu_busy) == $past($countones(cu_busy)) + 1));
endmodule

bind oc_collector oc_collector_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .cu_free      (cu_free),
  .disp_valid   (disp_valid),
  .cu_busy      (cu_busy),
  .disp_oh      (disp_oh),
  .wb_we        (wb_we),
  .bank_rd_en   (bank_rd_en),
  .bank_req     (bank_req),
  .bank_gnt     (bank_gnt),
  .row_gnt      (row_gnt),
  .row_rdy_flat (row_rdy_flat)
);

// File: tb/oc_collector_tb_top.sv
`timescale 1ns/1ps
module oc_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [2:0]  alloc_warp = '0;
  logic [5:0]  alloc_op = '0;
  logic [2:0]  alloc_src_vld = '0;
  logic [11:0] alloc_src_reg = '0;
  logic        cu_free;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_warp = '0;
  logic [3:0]  wb_reg = '0;
  logic [31:0] wb_data = '0;
  logic        disp_valid;
  logic [2:0]  disp_warp;
  logic [5:0]  disp_op;
  logic [2:0]  disp_src_vld;
  logic [95:0] disp_operands;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_rf [8][16];

  always #4 clk = ~clk;

  oc_collector dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_warp(alloc_warp), .alloc_op(alloc_op),
    .alloc_src_vld(alloc_src_vld), .alloc_src_reg(alloc_src_reg),
    .cu_free(cu_free),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .wb_data(wb_data),
    .disp_valid(disp_valid), .disp_warp(disp_warp), .disp_op(disp_op),
    .disp_src_vld(disp_src_vld), .disp_operands(disp_operands)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wb_write(input int w, input int r, input logic [31:0] d);
    wb_valid = 1'b1; wb_warp = 3'(w); wb_reg = 4'(r); wb_data = d;
    exp_rf[w][r] = d;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic alloc(input int w, input int op, input logic [2:0] vld,
                       input int r0, input int r1, input int r2);
    alloc_valid = 1'b1; alloc_warp = 3'(w); alloc_op = 6'(op); alloc_src_vld = vld;
    alloc_src_reg = {4'(r2), 4'(r1), 4'(r0)};
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic wait_disp(input int maxc, output int waited);
    waited = 0;
    while (!disp_valid && waited < maxc) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // offer one instruction, measure cycles to dispatch, check every field
  task automatic run_latency(input string tag, input int w, input int op, input logic [2:0] vld,
                             input int r0, input int r1, input int r2, input int exp_lat);
    int waited, lat;
    int regs [3];
    logic [31:0] ev;
    regs[0] = r0; regs[1] = r1; regs[2] = r2;
    alloc(w, op, vld, r0, r1, r2);
    wait_disp(10, waited);
    lat = 1 + waited;
    check(lat == exp_lat, {tag, " dispatch cycle"}, lat, exp_lat);
    check(disp_op == 6'(op) && disp_warp == 3'(w), {tag, " R4 op/warp"}, {disp_warp, disp_op}, {3'(w), 6'(op)});
    check(disp_src_vld == vld, {tag, " R4 src valid"}, disp_src_vld, vld);
    for (int k = 0; k < 3; k++) begin
      ev = vld[k] ? exp_rf[w][regs[k]] : 32'h0;
      check(disp_operands[k*32 +: 32] == ev, {tag, " R4 operand"}, disp_operands[k*32 +: 32], ev);
    end
    @(negedge clk);
  endtask

  // R7 and R8: rotation after reset, bank 1 held busy by writebacks to w0 r13
  task automatic t_rotation();
    wb_valid = 1'b1; wb_warp = 3'd0; wb_reg = 4'd13; wb_data = 32'h1111;
    alloc(0, 10, 3'b001, 1, 0, 0);         // unit 0, row index 0
    alloc(0, 11, 3'b001, 5, 0, 0);         // unit 1, row index 3
    wb_valid = 1'b0;                       // open bank 1 once: index 0 wins
    @(negedge clk);
    wb_valid = 1'b1;
    check(disp_valid && disp_op == 6'd10, "R7 first grant to index 0", disp_op, 10);
    @(negedge clk);
    check(cu_free == 1'b1, "R5 free after dispatch", cu_free, 1);
    alloc(0, 12, 3'b001, 9, 0, 0);         // unit 0 again, row index 0
    wb_valid = 1'b0;
    @(negedge clk);
    check(disp_valid && disp_op == 6'd11, "R7 rotation favours index 3", disp_op, 11);
    check(disp_operands[31:0] == 32'h0, "R8 reset register reads zero", disp_operands[31:0], 0);
    @(negedge clk);
    check(disp_valid && disp_op == 6'd12, "R7 index 0 served next", disp_op, 12);
    @(negedge clk);
    exp_rf[0][13] = 32'h1111;
  endtask

  task automatic t_wb_priority();
    int waited;
    // same bank, same register: read waits and returns the new value
    alloc_valid = 1'b1; alloc_warp = 3'd0; alloc_op = 6'd30; alloc_src_vld = 3'b001;
    alloc_src_reg = {4'd0, 4'd0, 4'd1};
    @(negedge clk);
    alloc_valid = 1'b0;
    wb_valid = 1'b1; wb_warp = 3'd0; wb_reg = 4'd1; wb_data = 32'hBEEF_0001;
    exp_rf[0][1] = 32'hBEEF_0001;
    @(negedge clk);
    wb_valid = 1'b0;
    check(disp_valid == 1'b0, "R2 read held behind writeback", disp_valid, 0);
    @(negedge clk);
    check(disp_valid == 1'b1, "R2 delayed dispatch", disp_valid, 1);
    check(disp_operands[31:0] == 32'hBEEF_0001, "R2 read sees written value",
          disp_operands[31:0], 32'hBEEF_0001);
    @(negedge clk);
    // writeback to another bank does not delay
    alloc(0, 31, 3'b001, 1, 0, 0);
    wb_valid = 1'b1; wb_warp = 3'd0; wb_reg = 4'd2; wb_data = 32'hBEEF_0002;
    exp_rf[0][2] = 32'hBEEF_0002;
    @(negedge clk);
    wb_valid = 1'b0;
    check(disp_valid == 1'b1 && disp_op == 6'd31, "R2 other bank no delay", disp_op, 31);
    check(disp_operands[31:0] == 32'hBEEF_0001, "R2 other bank value", disp_operands[31:0], 32'hBEEF_0001);
    @(negedge clk);
    wait_disp(2, waited);
  endtask

  task automatic t_full();
    int got, bogus;
    for (int k = 0; k < 4; k++) alloc(0, 20 + k, 3'b111, 0, 4, 8);
    check(cu_free == 1'b0, "R5 four units busy", cu_free, 0);
    alloc_valid = 1'b1; alloc_warp = 3'd0; alloc_op = 6'd63; alloc_src_vld = 3'b000;
    got = 0; bogus = 0;
    for (int k = 0; k < 40; k++) begin
      if (disp_valid) begin
        if (disp_op == 6'd63) bogus++;
        else begin
          got++;
          check(disp_operands == {exp_rf[0][8], exp_rf[0][4], exp_rf[0][0]},
                "R1 full-load operands", disp_operands[31:0], exp_rf[0][0]);
        end
      end
      @(negedge clk);
      alloc_valid = 1'b0;
    end
    check(got == 4, "R5 four dispatches", got, 4);
    check(bogus == 0, "R5 refused instruction never dispatched", bogus, 0);
    check(cu_free == 1'b1, "R5 free after drain", cu_free, 1);
    run_latency("R5 retry accepted", 4, 40, 3'b001, 3, 0, 0, 2);
  endtask

  task automatic t_order();
    int waited;
    // younger, conflict-free instruction overtakes
    alloc(3, 50, 3'b111, 1, 5, 9);
    alloc(2, 51, 3'b001, 0, 0, 0);
    @(negedge clk);
    check(disp_valid && disp_op == 6'd51, "R6 younger dispatches first", disp_op, 51);
    @(negedge clk);
    check(disp_valid && disp_op == 6'd50, "R6 older follows", disp_op, 50);
    @(negedge clk);
    // both ready together: lower unit first
    alloc(0, 52, 3'b011, 0, 4, 0);
    alloc(0, 53, 3'b001, 1, 0, 0);
    @(negedge clk);
    check(disp_valid && disp_op == 6'd52, "R6 lowest unit wins", disp_op, 52);
    @(negedge clk);
    check(disp_valid && disp_op == 6'd53, "R6 second unit next cycle", disp_op, 53);
    @(negedge clk);
    wait_disp(2, waited);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 16; r++) exp_rf[w][r] = 32'h0;
    check(cu_free == 1'b1, "R5 reset free", cu_free, 1);
    check(disp_valid == 1'b0, "R6 reset no dispatch", disp_valid, 0);
    t_rotation();
    for (int w = 0; w < 8; w++)
      for (int r = 0; r < 16; r++) wb_write(w, r, 32'hC000_0000 | 32'(w << 8) | 32'(r));
    run_latency("R1 R3 distinct banks", 2, 5, 3'b111, 0, 1, 2, 2);
    run_latency("R1 shared bank w0", 0, 6, 3'b011, 1, 5, 0, 3);
    run_latency("R1 shared bank w1", 1, 7, 3'b011, 3, 7, 0, 3);
    run_latency("R1 rotated apart w1", 1, 8, 3'b011, 0, 3, 0, 2);
    run_latency("R1 three in one bank", 3, 9, 3'b111, 1, 5, 9, 4);
    run_latency("R3 no sources", 6, 10, 3'b000, 0, 0, 0, 1);
    run_latency("R4 middle row only", 5, 11, 3'b010, 0, 6, 0, 2);
    t_wb_priority();
    t_full();
    t_order();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule